// File: doc/BRIEF.md
# Line Port Channel Buffer with Empty/Full Flags

This block sits between a CPU bus and the serial framer of one line-interface port that carries two bearer channels (B1, B2) and one signalling channel (D). On the transmit side the CPU loads a data register for each B channel. When the framer pulses its frame strobe, the block copies each register into a shadow register that the framer shifts out. On the receive side the same strobe latches the incoming B1, B2 and D bits into three holding registers, and the CPU reads them from there.

Five flags track the buffers. A transmit flag reports that its data register has moved to the shadow and can be refilled. A receive flag reports that its holding register has unread data. Hardware transfers set the flags. The CPU clears a flag only as a side effect of an access to the matching data register, and a write to the status address never clears one. The OR of the five flags drives an interrupt line.

Top module: `chbuf_port`

## Requirements
- R1: While `rst` is high, every data, shadow and holding register clears to zero, both transmit-empty flags become 1 and all three receive-full flags become 0. The status therefore reads 0x18 and `irq` is 1.
- R2: A clock edge with `frame_stb` high copies each B transmit data register into its shadow output (`tx_b1`, `tx_b2`) and sets that channel's transmit-empty flag. The shadows do not change on any other edge.
- R3: A CPU write (`cpu_sel`=1, `cpu_we`=1) to address 0 (B1) or 1 (B2) loads that transmit data register and clears its transmit-empty flag. When the write and the frame strobe share an edge, the shadow takes the register's previous content and the flag ends at 0.
- R4: A clock edge with `frame_stb` high loads `rx_b1`, `rx_b2` and `rx_d` into the holding registers and sets all three receive-full flags. Without the strobe, no receive-full flag can go from 0 to 1.
- R5: A CPU read (`cpu_sel`=1, `cpu_we`=0) of address 2 (B1), 3 (B2) or 4 (D, zero-extended) returns that holding register on `cpu_rdata` in the same cycle and clears only that channel's receive-full flag.
- R6: When a read of a receive address and a frame strobe share an edge, the read returns the old content, the flag stays 1 and the new content is returned by the next read.
- R7: Reads are combinational. Addresses 0 and 1 return the transmit data registers. Address 5 returns the status, with zero in bits 7..5. Addresses 6 and 7 return 0. The status bits are: bit 4 B2 transmit-empty, bit 3 B1 transmit-empty, bit 2 D receive-full, bit 1 B2 receive-full, bit 0 B1 receive-full.
- R8: A write to address 5, 2, 3, 4, 6 or 7 changes no flag and no register.
- R9: `irq` is 1 exactly when at least one of the five flags is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | CPU access strobe for this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | B_W | Write data |
| cpu_rdata | output | B_W | Combinational read data |
| frame_stb | input | 1 | Framer frame strobe |
| rx_b1 | input | B_W | Received B1 bits |
| rx_b2 | input | B_W | Received B2 bits |
| rx_d | input | D_W | Received D bits |
| tx_b1 | output | B_W | B1 transmit shadow |
| tx_b2 | output | B_W | B2 transmit shadow |
| irq | output | 1 | OR of all five flags |

## Verification
Directed sequences come first. They cover the reset state, a lone write and a lone strobe, and then the two same-edge collisions (write with strobe, read with strobe), which separate "clear wins" from "set wins". A write to the status address followed by a status read shows whether that write reaches the flags. A run that drains every buffer confirms the interrupt can return to 0. A seeded random run then mixes reads, writes, strobes and stray addresses against a reference model. That run exposes wrong priorities, cross-channel clearing and address-decode mistakes that the directed cases do not reach.

// File: rtl/chbuf_pkg.sv
package chbuf_pkg;

    localparam int ADDR_W = 3;
    localparam int NUM_B  = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_TX_B1  = 3'd0,
        ADDR_TX_B2  = 3'd1,
        ADDR_RX_B1  = 3'd2,
        ADDR_RX_B2  = 3'd3,
        ADDR_RX_D   = 3'd4,
        ADDR_STATUS = 3'd5
    } chbuf_addr_e;

    // Bit order is part of the register contract (R7).
    typedef struct packed {
        logic b2_tx_empty;
        logic b1_tx_empty;
        logic d_rx_full;
        logic b2_rx_full;
        logic b1_rx_full;
    } chbuf_status_t;

    localparam int STATUS_W = $bits(chbuf_status_t);

    function automatic logic [ADDR_W-1:0] tx_addr(input int idx);
        return (idx == 0) ? ADDR_TX_B1 : ADDR_TX_B2;
    endfunction

    function automatic logic [ADDR_W-1:0] rx_b_addr(input int idx);
        return (idx == 0) ? ADDR_RX_B1 : ADDR_RX_B2;
    endfunction

endpackage

// File: rtl/chbuf_tx_lane.sv
module chbuf_tx_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         xfer,
    output logic [W-1:0] data_q,
    output logic [W-1:0] shadow_q,
    output logic         empty_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q   <= '0;
            shadow_q <= '0;
            empty_q  <= 1'b1;
        end else begin
            if (xfer) begin
                shadow_q <= data_q;
            end
            if (wr_en) begin
                data_q <= wr_data;
            end
            // A fresh CPU write outranks the transfer: the new byte is not yet in the shadow.
            if (wr_en) begin
                empty_q <= 1'b0;
            end else if (xfer) begin
                empty_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/chbuf_rx_lane.sv
module chbuf_rx_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_en,
    input  logic         latch,
    input  logic [W-1:0] din,
    output logic [W-1:0] hold_q,
    output logic         full_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (latch) begin
                hold_q <= din;
            end
            // New arrival outranks the read-clear.
            if (latch) begin
                full_q <= 1'b1;
            end else if (rd_en) begin
                full_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/chbuf_port.sv
module chbuf_port
    import chbuf_pkg::*;
#(
    parameter int B_W = 8,
    parameter int D_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [B_W-1:0]    cpu_wdata,
    output logic [B_W-1:0]    cpu_rdata,
    input  logic              frame_stb,
    input  logic [B_W-1:0]    rx_b1,
    input  logic [B_W-1:0]    rx_b2,
    input  logic [D_W-1:0]    rx_d,
    output logic [B_W-1:0]    tx_b1,
    output logic [B_W-1:0]    tx_b2,
    output logic              irq
);

    localparam int PAD_D = B_W - D_W;
    localparam int PAD_S = B_W - STATUS_W;

    logic                 cpu_wr;
    logic                 cpu_rd;
    logic [B_W-1:0]       tx_data   [NUM_B];
    logic [B_W-1:0]       tx_shadow [NUM_B];
    logic [NUM_B-1:0]     tx_empty;
    logic [B_W-1:0]       rx_b_in   [NUM_B];
    logic [B_W-1:0]       rx_b_hold [NUM_B];
    logic [NUM_B-1:0]     rx_b_full;
    logic [D_W-1:0]       rx_d_hold;
    logic                 rx_d_full;
    logic                 rx_d_rd;
    chbuf_status_t        status;
    logic [STATUS_W-1:0]  flags;

    assign cpu_wr = cpu_sel &&  cpu_we;
    assign cpu_rd = cpu_sel && !cpu_we;

    assign rx_b_in[0] = rx_b1;
    assign rx_b_in[1] = rx_b2;

    for (genvar i = 0; i < NUM_B; i++) begin : g_tx
        chbuf_tx_lane #(.W(B_W)) u_tx (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (cpu_wr && (cpu_addr == tx_addr(i))),
            .wr_data  (cpu_wdata),
            .xfer     (frame_stb),
            .data_q   (tx_data[i]),
            .shadow_q (tx_shadow[i]),
            .empty_q  (tx_empty[i])
        );
    end

    for (genvar i = 0; i < NUM_B; i++) begin : g_rxb
        chbuf_rx_lane #(.W(B_W)) u_rx (
            .clk    (clk),
            .rst    (rst),
            .rd_en  (cpu_rd && (cpu_addr == rx_b_addr(i))),
            .latch  (frame_stb),
            .din    (rx_b_in[i]),
            .hold_q (rx_b_hold[i]),
            .full_q (rx_b_full[i])
        );
    end

    assign rx_d_rd = cpu_rd && (cpu_addr == ADDR_RX_D);

    chbuf_rx_lane #(.W(D_W)) u_rx_d (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rx_d_rd),
        .latch  (frame_stb),
        .din    (rx_d),
        .hold_q (rx_d_hold),
        .full_q (rx_d_full)
    );

    always_comb begin
        status.b2_tx_empty = tx_empty[1];
        status.b1_tx_empty = tx_empty[0];
        status.d_rx_full   = rx_d_full;
        status.b2_rx_full  = rx_b_full[1];
        status.b1_rx_full  = rx_b_full[0];
    end

    assign flags = status;
    assign irq   = |flags;
    assign tx_b1 = tx_shadow[0];
    assign tx_b2 = tx_shadow[1];

    always_comb begin
        case (cpu_addr)
            ADDR_TX_B1:  cpu_rdata = tx_data[0];
            ADDR_TX_B2:  cpu_rdata = tx_data[1];
            ADDR_RX_B1:  cpu_rdata = rx_b_hold[0];
            ADDR_RX_B2:  cpu_rdata = rx_b_hold[1];
            ADDR_RX_D:   cpu_rdata = {{PAD_D{1'b0}}, rx_d_hold};
            ADDR_STATUS: cpu_rdata = {{PAD_S{1'b0}}, flags};
            default:     cpu_rdata = '0;
        endcase
    end

endmodule

// File: rtl/chbuf_port_sva.sv
module chbuf_port_sva
    import chbuf_pkg::*;
#(
    parameter int B_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                cpu_sel,
    input logic                cpu_we,
    input logic [ADDR_W-1:0]   cpu_addr,
    input logic                frame_stb,
    input logic [STATUS_W-1:0] flags,
    input logic [B_W-1:0]      tx_b1,
    input logic [B_W-1:0]      tx_b2,
    input logic                irq
);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (flags == 5'b11000) && (tx_b1 == '0) && (tx_b2 == '0));

    p_tx_set_r2: assert property (@(posedge clk) disable iff (rst)
        frame_stb && !(cpu_sel && cpu_we && cpu_addr == ADDR_TX_B1) |=> flags[3]);

    p_shadow_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(tx_b1) && $stable(tx_b2));

    p_tx_clr_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_sel && cpu_we && cpu_addr == ADDR_TX_B2 |=> !flags[4]);

    p_rx_set_r4: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> flags[2:0] == 3'b111);

    p_rx_norise_r4: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> (flags[2:0] & ~$past(flags[2:0])) == 3'b000);

    p_rx_clr_r5: assert property (@(posedge clk) disable iff (rst)
        cpu_sel && !cpu_we && cpu_addr == ADDR_RX_D && !frame_stb |=> !flags[2]);

    p_rd_latch_r6: assert property (@(posedge clk) disable iff (rst)
        cpu_sel && !cpu_we && cpu_addr == ADDR_RX_B1 && frame_stb |=> flags[0]);

    p_status_wr_r8: assert property (@(posedge clk) disable iff (rst)
        cpu_sel && cpu_we && cpu_addr == ADDR_STATUS && !frame_stb |=> $stable(flags));

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cpu_sel |=> !$fell(irq));

endmodule

bind chbuf_port chbuf_port_sva #(.B_W(B_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .cpu_sel   (cpu_sel),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .frame_stb (frame_stb),
    .flags     (flags),
    .tx_b1     (tx_b1),
    .tx_b2     (tx_b2),
    .irq       (irq)
);

// File: tb/chbuf_port_tb_top.sv
`timescale 1ns/1ps
module chbuf_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_sel = 1'b0;
    logic       cpu_we = 1'b0;
    logic [2:0] cpu_addr = 3'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic       frame_stb = 1'b0;
    logic [7:0] rx_b1 = 8'd0;
    logic [7:0] rx_b2 = 8'd0;
    logic [1:0] rx_d = 2'd0;
    logic [7:0] tx_b1;
    logic [7:0] tx_b2;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    logic [7:0] m_txd [2];
    logic [7:0] m_sh  [2];
    logic [7:0] m_h1, m_h2;
    logic [1:0] m_hd;
    logic [4:0] m_fl;   // [4] b2 tx empty .. [0] b1 rx full

    always #2.5 clk = ~clk;

    chbuf_port dut_i (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .frame_stb(frame_stb), .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_d(rx_d),
        .tx_b1(tx_b1), .tx_b2(tx_b2), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_txd[0];
            3'd1: return m_txd[1];
            3'd2: return m_h1;
            3'd3: return m_h2;
            3'd4: return {6'd0, m_hd};
            3'd5: return {3'd0, m_fl};
            default: return 8'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_txd[0] = 8'd0; m_txd[1] = 8'd0;
        m_sh[0]  = 8'd0; m_sh[1]  = 8'd0;
        m_h1 = 8'd0; m_h2 = 8'd0; m_hd = 2'd0;
        m_fl = 5'b11000;
    endtask

    task automatic model_edge(input logic s, input logic w, input logic [2:0] a,
                              input logic [7:0] wd, input logic stb,
                              input logic [7:0] r1, input logic [7:0] r2, input logic [1:0] rd);
        if (stb) begin
            m_sh[0] = m_txd[0]; m_sh[1] = m_txd[1];
            m_fl[3] = 1'b1; m_fl[4] = 1'b1;
            m_h1 = r1; m_h2 = r2; m_hd = rd;
            m_fl[2:0] = 3'b111;
        end
        if (s && w && a == 3'd0) begin m_txd[0] = wd; m_fl[3] = 1'b0; end
        if (s && w && a == 3'd1) begin m_txd[1] = wd; m_fl[4] = 1'b0; end
        if (s && !w && !stb) begin
            if (a == 3'd2) m_fl[0] = 1'b0;
            if (a == 3'd3) m_fl[1] = 1'b0;
            if (a == 3'd4) m_fl[2] = 1'b0;
        end
    endtask

    // One bus cycle: check registered outputs, drive, check read data, advance model.
    task automatic cyc(input logic s, input logic w, input logic [2:0] a, input logic [7:0] wd,
                       input logic stb, input logic [7:0] r1, input logic [7:0] r2,
                       input logic [1:0] rd, input string tag);
        @(negedge clk);
        check(tx_b1 == m_sh[0], "R2 tx_b1", tx_b1, m_sh[0]);
        check(tx_b2 == m_sh[1], "R2 tx_b2", tx_b2, m_sh[1]);
        check(irq == (|m_fl), "R9 irq", {7'd0, irq}, {7'd0, |m_fl});
        cpu_sel = s; cpu_we = w; cpu_addr = a; cpu_wdata = wd;
        frame_stb = stb; rx_b1 = r1; rx_b2 = r2; rx_d = rd;
        #1;
        if (s && !w) check(cpu_rdata == exp_rd(a), tag, cpu_rdata, exp_rd(a));
        model_edge(s, w, a, wd, stb, r1, r2, rd);
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        cyc(1'b1, 1'b0, a, 8'd0, 1'b0, 8'd0, 8'd0, 2'd0, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
        cyc(1'b1, 1'b1, a, d, 1'b0, 8'd0, 8'd0, 2'd0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(3'd5, "R1 status after reset");
        rd(3'd0, "R1 tx data after reset");
        rd(3'd2, "R1 rx hold after reset");

        // R3: write clears transmit-empty
        wr(3'd0, 8'hA5, "R3");
        rd(3'd5, "R3 status after B1 write");
        rd(3'd0, "R7 readback B1");

        // R2/R4: strobe transfers and latches
        cyc(1'b0, 1'b0, 3'd0, 8'd0, 1'b1, 8'h3C, 8'hC3, 2'b10, "R4");
        rd(3'd5, "R4 status after strobe");
        rd(3'd4, "R5 D read");
        rd(3'd5, "R5 only D cleared");

        // R6: read and latch on the same edge
        cyc(1'b1, 1'b0, 3'd2, 8'd0, 1'b1, 8'h77, 8'h11, 2'b01, "R6 old data on collision");
        rd(3'd5, "R6 flag kept");
        rd(3'd2, "R6 new data");

        // R3: write and strobe on the same edge
        wr(3'd1, 8'h5A, "R3");
        cyc(1'b1, 1'b1, 3'd1, 8'h99, 1'b1, 8'h01, 8'h02, 2'b11, "R3");
        rd(3'd5, "R3 write beats strobe");

        // R8: writes to read-only addresses
        wr(3'd5, 8'h00, "R8");
        wr(3'd2, 8'hFF, "R8");
        wr(3'd6, 8'hFF, "R8");
        rd(3'd5, "R8 status unchanged");
        rd(3'd2, "R8 hold unchanged");
        rd(3'd6, "R7 unused address");

        // R9: drain every flag
        wr(3'd0, 8'h10, "R9");
        wr(3'd1, 8'h20, "R9");
        rd(3'd2, "R5 B1 read");
        rd(3'd3, "R5 B2 read");
        rd(3'd4, "R5 D read");
        rd(3'd5, "R9 all flags clear");
        rd(3'd5, "R9 still clear");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic s, w, stb;
            logic [2:0] a;
            s   = ($urandom % 3) != 0;
            w   = $urandom % 2;
            a   = 3'($urandom % 8);
            stb = ($urandom % 5) == 0;
            cyc(s, w, a, 8'($urandom), stb, 8'($urandom), 8'($urandom), 2'($urandom),
                (a >= 3'd2 && a <= 3'd4) ? "R5 random read" : "R7 random read");
        end

        @(negedge clk);
        check(tx_b1 == m_sh[0], "R2 final tx_b1", tx_b1, m_sh[0]);
        check(irq == (|m_fl), "R9 final irq", {7'd0, irq}, {7'd0, |m_fl});
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule